// File: doc/BRIEF.md
# Serial CRC Generator and Checker

This block divides a serial bit stream by a fixed generator polynomial over GF(2), taking one bit per clock. All of its arithmetic is modulo 2, so every addition or subtraction is a bitwise XOR with no carry or borrow. The polynomial and its degree `W` are chosen at build time. The polynomial must have both its highest and its lowest coefficient set. The parameter `POLY` holds the coefficients below the top term. Its default is the CRC-8 generator x^8+x^5+x^4+1, which is `POLY = 8'h31`.

The same division engine serves both directions of a link.

- **Generate mode:** the block takes a k-bit message and returns the remainder of that message times x^r (the message followed by `W` zero bits) divided by the generator. No zero bits are clocked in for this; the engine folds them into the feedback. The `W` remainder bits are then shifted out so that they can follow the message on the wire. The frame on the wire is therefore k+`W` bits long.
- **Check mode:** the block divides a whole received codeword. It flags an error when the remainder is not zero, and the frame is then to be discarded, because a CRC cannot locate the faulty bit.

For example, with generator 110101 (degree 5), the message 1010001101 yields the check field 01110, and the frame sent is 101000110101110.

Top module: `crc_serial_unit`

## Requirements
- R1: After reset the outputs are as follows: `rem` is all zeros, `err` is 0, `done` is 0 and `dout_valid` is 0.
- R2: A cycle with `start` high clears `rem` to zero and clears `err`. It also latches `mode`, where 0 selects generate and 1 selects check. The level of `mode` outside a start cycle has no effect.
- R3: In the following cycles `rem` does not change: cycles with `din_valid` low, and cycles in which no frame is open (before `start`, after the last bit, or while the check field is being shifted out).
- R4: In generate mode, on the cycle after the bit marked by `din_last` is taken, `rem` equals the remainder of (message · x^W) mod G. The message is sent most significant bit first. Bit `W-1` of `rem` is the highest-order coefficient.
- R5: In generate mode, in the `W` cycles after the last message bit, `dout_valid` is high and `dout` carries the remainder most significant bit first. `done` then goes high for exactly one cycle.
- R6: In check mode, one cycle after the bit marked by `din_last` is taken, `err` is high exactly when the received k+`W` bit word is not divisible by G, and `done` pulses for one cycle. For example, 101000110101110 with G = 110101 gives `err` = 0.
- R7: `err` keeps its value until the next `start`.
- R8: With the default parameters the block implements CRC-8, generator code 100110001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Opens a frame: clears the remainder and latches the mode |
| mode | input | 1 | 0 = generate check field, 1 = check a codeword |
| din | input | 1 | Serial data bit, most significant first |
| din_valid | input | 1 | `din` holds a bit to be taken this cycle |
| din_last | input | 1 | Marks the final bit of the frame; qualified by `din_valid` |
| dout | output | 1 | Serial check field bit |
| dout_valid | output | 1 | `dout` carries a check field bit |
| done | output | 1 | One-cycle pulse at the end of a frame |
| rem | output | W | Running remainder |
| err | output | 1 | Check mode: nonzero remainder over the codeword |

## Verification
The hardest cases to reach from the ports are these:
- an idle `din_valid` gap that falls right before the marked last bit;
- a flipped mode level during a frame;
- the check result that must survive later traffic until a new start.

The random frames therefore do three things:
- they insert gaps with random `din` at arbitrary positions;
- they invert `mode` immediately after each start;
- they keep driving valid bits after every check.

Two instances see the same stream, one with degree 8 and one with the degree-5 example polynomial. This covers two generator widths and the worked example in a single run.

// File: rtl/crc_serial_unit.sv
module crc_serial_unit #(
  parameter int W = 8,
  parameter logic [W-1:0] POLY = 'h31
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         mode,
  input  logic         din,
  input  logic         din_valid,
  input  logic         din_last,
  output logic         dout,
  output logic         dout_valid,
  output logic         done,
  output logic [W-1:0] rem,
  output logic         err
);
  localparam int CW = $clog2(W) + 1;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_SHIFT} st_t;

  st_t           state;
  logic          mode_q;
  logic          pend_q;
  logic [W-1:0]  rem_q;
  logic [W-1:0]  sreg_q;
  logic [CW-1:0] cnt_q;

  wire         fb     = rem_q[W-1] ^ din;
  wire [W-1:0] rem_nx = {rem_q[W-2:0], 1'b0} ^ (fb ? POLY : '0);

  assign rem        = rem_q;
  assign dout       = sreg_q[W-1];
  assign dout_valid = (state == S_SHIFT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      mode_q <= 1'b0;
      pend_q <= 1'b0;
      rem_q  <= '0;
      sreg_q <= '0;
      cnt_q  <= '0;
      err    <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        state  <= S_RUN;
        mode_q <= mode;
        pend_q <= 1'b0;
        rem_q  <= '0;
        cnt_q  <= '0;
        err    <= 1'b0;
      end else begin
        if (pend_q) begin
          err    <= |rem_q;
          done   <= 1'b1;
          pend_q <= 1'b0;
        end
        case (state)
          S_RUN: if (din_valid) begin
            rem_q <= rem_nx;
            if (din_last) begin
              if (!mode_q) begin
                sreg_q <= rem_nx;
                cnt_q  <= '0;
                state  <= S_SHIFT;
              end else begin
                pend_q <= 1'b1;
                state  <= S_IDLE;
              end
            end
          end
          S_SHIFT: begin
            sreg_q <= {sreg_q[W-2:0], 1'b0};
            cnt_q  <= cnt_q + 1'b1;
            if (cnt_q == CW'(W - 1)) begin
              state <= S_IDLE;
              done  <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/crc_serial_unit_chk.sv
module crc_serial_unit_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         din_valid,
  input logic         done,
  input logic         err,
  input logic         dout_valid,
  input logic [W-1:0] rem
);
  p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (rem == '0 && !err));

  p_rem_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !din_valid) |=> $stable(rem));

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid |-> !done);

  p_err_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (done || $stable(err)));
endmodule

bind crc_serial_unit crc_serial_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .din_valid(din_valid),
  .done(done), .err(err), .dout_valid(dout_valid), .rem(rem)
);

// File: tb/tb_crc_serial_unit.sv
`timescale 1ns/1ps
module tb_crc_serial_unit;
  logic clk = 0, rst_n = 0;
  logic start = 0, mode = 0, din = 0, din_valid = 0, din_last = 0;
  logic dout8, dv8, done8, err8, dout5, dv5, done5, err5;
  logic [7:0] rem8;
  logic [4:0] rem5;
  int checks = 0, fails = 0;

  localparam logic [32:0] G8 = 33'h131;
  localparam logic [32:0] G5 = 33'h35;

  always #2.5 clk = ~clk;

  crc_serial_unit dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .din(din),
    .din_valid(din_valid), .din_last(din_last), .dout(dout8), .dout_valid(dv8),
    .done(done8), .rem(rem8), .err(err8));

  crc_serial_unit #(.W(5), .POLY(5'h15)) dut5 (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .din(din),
    .din_valid(din_valid), .din_last(din_last), .dout(dout5), .dout_valid(dv5),
    .done(done5), .rem(rem5), .err(err5));

  function automatic logic [31:0] ref_div(input logic [63:0] bits, input int n,
                                          input logic [32:0] g, input int w, input bit aug);
    logic [32:0] r = '0;
    int tot = n + (aug ? w : 0);
    for (int i = 0; i < tot; i++) begin
      bit b = (i < n) ? bits[n-1-i] : 1'b0;
      r = (r << 1) | 33'(b);
      if (r[w]) r = r ^ g;
    end
    return r[31:0];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic open_frame(input logic m);
    start = 1; mode = m;
    @(negedge clk);
    start = 0; mode = ~m;
    chk(rem8 == 0 && rem5 == 0 && !err8 && !err5, "R2 start clear", {rem8, rem5}, 0);
  endtask

  task automatic feed(input logic [63:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      if ($urandom % 4 == 0) begin
        logic [7:0] h8 = rem8;
        logic [4:0] h5 = rem5;
        din_valid = 0; din = 1'($urandom); din_last = 1'($urandom);
        @(negedge clk);
        chk(rem8 == h8 && rem5 == h5, "R3 gap hold", {rem8, rem5}, {h8, h5});
      end
      din = bits[i]; din_valid = 1; din_last = (i == 0);
      @(negedge clk);
    end
    din_valid = 0; din_last = 0;
  endtask

  task automatic run_gen(input logic [63:0] m, input int k);
    logic [7:0] b8 = 0; logic [4:0] b5 = 0;
    int n8 = 0, n5 = 0, d8 = 0, d5 = 0;
    logic [7:0] e8 = 8'(ref_div(m, k, G8, 8, 1));
    logic [4:0] e5 = 5'(ref_div(m, k, G5, 5, 1));
    open_frame(0);
    feed(m, k);
    chk(rem8 == e8, "R4 rem w8", rem8, e8);
    chk(rem5 == e5, "R4 rem w5", rem5, e5);
    for (int c = 0; c < 12; c++) begin
      if (dv8) begin b8 = {b8[6:0], dout8}; n8++; end
      if (dv5) begin b5 = {b5[3:0], dout5}; n5++; end
      if (done8) d8++;
      if (done5) d5++;
      din = 1'($urandom); din_valid = 1'($urandom);
      @(negedge clk);
    end
    din_valid = 0;
    chk(b8 == e8 && n8 == 8 && d8 == 1, "R5 shift w8", {b8, 8'(n8), 8'(d8)}, {e8, 8'd8, 8'd1});
    chk(b5 == e5 && n5 == 5 && d5 == 1, "R5 shift w5", {b5, 8'(n5), 8'(d5)}, {e5, 8'd5, 8'd1});
    chk(rem8 == e8, "R3 idle hold", rem8, e8);
  endtask

  task automatic run_chk(input logic [63:0] w, input int n);
    logic e8 = ref_div(w, n, G8, 8, 0) != 0;
    logic e5 = ref_div(w, n, G5, 5, 0) != 0;
    open_frame(1);
    feed(w, n);
    chk(!done8 && !err8, "R6 no early result", {done8, err8}, 0);
    @(negedge clk);
    chk(err8 == e8 && done8, "R6 err w8", {done8, err8}, {1'b1, e8});
    chk(err5 == e5 && done5, "R6 err w5", {done5, err5}, {1'b1, e5});
    for (int c = 0; c < 4; c++) begin
      din = 1'($urandom); din_valid = 1; din_last = 1'($urandom);
      @(negedge clk);
    end
    din_valid = 0; din_last = 0;
    chk(err8 == e8 && err5 == e5, "R7 err hold", {err8, err5}, {e8, e5});
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(rem8 == 0 && !err8 && !done8 && !dv8, "R1 reset", {rem8, err8, done8, dv8}, 0);
    rst_n = 1;
    @(negedge clk);
    din = 1; din_valid = 1;
    @(negedge clk);
    din_valid = 0;
    chk(rem8 == 0, "R3 valid before start", rem8, 0);

    run_gen(64'b1010001101, 10);
    chk(rem5 == 5'b01110, "R4 worked example", rem5, 5'b01110);
    run_chk(64'b101000110101110, 15);
    chk(!err5, "R6 worked example", err5, 0);

    run_gen(64'h1, 1);
    chk(rem8 == 8'h31, "R8 crc8 x^8 mod G", rem8, 8'h31);

    for (int t = 0; t < 40; t++) begin
      int k = 1 + int'($urandom % 40);
      logic [63:0] m = {$urandom, $urandom} & ((64'd1 << k) - 1);
      logic [7:0] c8 = 8'(ref_div(m, k, G8, 8, 1));
      logic [63:0] cw = (m << 8) | 64'(c8);
      if (t % 2 == 0) begin
        run_gen(m, k);
      end else begin
        if ($urandom % 2 == 1) cw = cw ^ (64'd1 << ($urandom % (k + 8)));
        run_chk(cw, k + 8);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule